// File: doc/BRIEF.md
# Dynamic-Threshold Preamble Boundary Detector

This block locates the point in a multi-symbol OFDM preamble where the repeated synchronisation symbols give way to their sign-inverted copies. Once the FFT window has been located upstream, a one-cycle `arm_i` pulse starts the search. From then on the block takes one autocorrelation result and one signal-power sum per symbol, each marked by `sym_valid_i`. The preamble it expects has 21 repeated symbols, then 3 sign-inverted symbols, then 6 channel-estimation symbols.

For each symbol the block adds the current correlation result to the previous one, and the current power to the previous power. It compares this pair metric against an adaptive threshold. The threshold is the correlation-to-power ratio of the last pair that passed, shifted right by 1 to 3 bits and scaled by the current power sum. The comparison is cross-multiplied, so no divider is needed.

At the sign change the pair metric collapses towards zero. The block then emits a single boundary pulse that carries the symbol index. If no boundary appears within the timeout window, it emits a timeout pulse instead.

Top module: `preamble_bnd_det`

## Requirements
- R1: After reset, `bnd_pulse_o` and `tmo_pulse_o` are low and the block is idle.
- R2: Symbols are accepted only after `arm_i`. Symbols that arrive while idle have no effect. A new `arm_i` restarts the search with the symbol index at 0. A symbol that arrives in the same cycle as `arm_i` is dropped.
- R3: The pair metric is the current correlation plus the previous correlation of the same search. The first accepted symbol (index 0) only stores its values. The second (index 1) sets the first reference. Decisions start at index 2.
- R4: A symbol is "below" when `pair_corr * ref_pwr < (ref_corr >>> s) * pair_pwr`, evaluated as signed arithmetic. Here `pair_pwr` is the current power plus the previous power, and `ref_corr`/`ref_pwr` are the stored reference pair.
- R5: When a decided symbol is not below, its pair metric and power sum replace the reference, so the threshold follows the channel level.
- R6: `ratio_sel_i` sets the shift `s`: value 0 gives 1, value 1 gives 2, and values 2 and 3 give 3. The current select value applies at each comparison.
- R7: When an accepted symbol is below, `bnd_pulse_o` is high for exactly one cycle, in the cycle after that symbol is accepted. `bnd_index_o` then holds that symbol's 0-based index counted from the arm.
- R8: After a boundary pulse the search stops. Further symbols produce neither pulse until the block is armed again.
- R9: If the symbol at index `TIMEOUT_SYMS-1` (23 by default) is not below, `tmo_pulse_o` is high for one cycle and the search stops. A boundary pulse and a timeout pulse never occur together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_i | input | 1 | Start or restart the boundary search |
| sym_valid_i | input | 1 | One-cycle strobe marking a symbol's results |
| corr_i | input | CORR_W | Signed per-symbol autocorrelation result |
| pwr_i | input | PWR_W | Unsigned per-symbol signal-power sum |
| ratio_sel_i | input | SEL_W | Threshold shift select |
| bnd_pulse_o | output | 1 | Boundary found (one cycle) |
| bnd_index_o | output | IDX_W | Index of the first inverted symbol |
| tmo_pulse_o | output | 1 | No boundary within the window (one cycle) |

## Verification
The case hardest to reach from the ports is a threshold that has moved away from its first value. A drop that a fixed threshold would flag must pass, and only a later, sharper drop may fire.

The bench reaches this case in several steps. It feeds a steady level, then a gradual decline, and then a sign flip. Each step is small enough to stay above half the previous pair metric, so the boundary is flagged at the flip and not at the first decline.

Separate directed runs isolate the other effects. One changes only the power at a single symbol, to show the power weighting. One repeats a sequence under every shift select. One places a negative step at index 1, to show that the first decision comes at index 2.

// File: rtl/pbd_pkg.sv
package pbd_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_HUNT = 1'b1
   } pbd_state_e;

   // Maps a select code to a right-shift amount, saturating at max_sh.
   function automatic int shift_of(input int code, input int max_sh);
      int s;
      s = code + 1;
      return (s > max_sh) ? max_sh : s;
   endfunction

endpackage

// File: rtl/pbd_pair_sum.sv
module pbd_pair_sum #(
   parameter int CORR_W = 16,
   parameter int PWR_W  = 16,
   localparam int SUM_W  = CORR_W + 1,
   localparam int PSUM_W = PWR_W + 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clear,
   input  logic                     take,
   input  logic signed [CORR_W-1:0] corr,
   input  logic        [PWR_W-1:0]  pwr,
   output logic                     pair_ok,
   output logic signed [SUM_W-1:0]  pair_corr,
   output logic        [PSUM_W-1:0] pair_pwr
);

   logic signed [CORR_W-1:0] prev_corr;
   logic        [PWR_W-1:0]  prev_pwr;
   logic                     have_prev;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_corr <= '0;
         prev_pwr  <= '0;
         have_prev <= 1'b0;
      end else if (clear) begin
         have_prev <= 1'b0;
      end else if (take) begin
         prev_corr <= corr;
         prev_pwr  <= pwr;
         have_prev <= 1'b1;
      end
   end

   assign pair_ok   = have_prev;
   assign pair_corr = SUM_W'(corr) + SUM_W'(prev_corr);
   assign pair_pwr  = PSUM_W'(pwr) + PSUM_W'(prev_pwr);

endmodule

// File: rtl/pbd_thresh.sv
module pbd_thresh
   import pbd_pkg::*;
#(
   parameter int CORR_W    = 16,
   parameter int PWR_W     = 16,
   parameter int SEL_W     = 2,
   parameter int MAX_SHIFT = 3,
   localparam int SUM_W  = CORR_W + 1,
   localparam int PSUM_W = PWR_W + 1,
   localparam int PROD_W = SUM_W + PSUM_W + 1,
   localparam int NSEL   = 1 << SEL_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clear,
   input  logic                     take,
   input  logic                     pair_ok,
   input  logic signed [SUM_W-1:0]  pair_corr,
   input  logic        [PSUM_W-1:0] pair_pwr,
   input  logic        [SEL_W-1:0]  sel,
   output logic                     below
);

   logic signed [SUM_W-1:0]  ref_corr;
   logic        [PSUM_W-1:0] ref_pwr;
   logic                     have_ref;

   // One scaled copy of the reference per select code.
   logic signed [SUM_W-1:0] scaled [NSEL];

   for (genvar v = 0; v < NSEL; v++) begin : g_scale
      localparam int SH = shift_of(v, MAX_SHIFT);
      assign scaled[v] = ref_corr >>> SH;
   end

   logic signed [SUM_W-1:0]  ref_sel;
   logic signed [PROD_W-1:0] a_ext, b_ext, c_ext, d_ext;
   logic signed [PROD_W-1:0] lhs, rhs;

   always_comb begin
      ref_sel = scaled[sel];
      a_ext   = {{(PROD_W-SUM_W){pair_corr[SUM_W-1]}}, pair_corr};
      b_ext   = {{(PROD_W-PSUM_W){1'b0}}, ref_pwr};
      c_ext   = {{(PROD_W-SUM_W){ref_sel[SUM_W-1]}}, ref_sel};
      d_ext   = {{(PROD_W-PSUM_W){1'b0}}, pair_pwr};
      lhs     = a_ext * b_ext;
      rhs     = c_ext * d_ext;
      below   = pair_ok && have_ref && (lhs < rhs);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ref_corr <= '0;
         ref_pwr  <= '0;
         have_ref <= 1'b0;
      end else if (clear) begin
         have_ref <= 1'b0;
      end else if (take && pair_ok && !below) begin
         ref_corr <= pair_corr;
         ref_pwr  <= pair_pwr;
         have_ref <= 1'b1;
      end
   end

endmodule

// File: rtl/pbd_seq.sv
module pbd_seq
   import pbd_pkg::*;
#(
   parameter int TIMEOUT_SYMS = 24,
   localparam int IDX_W = $clog2(TIMEOUT_SYMS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             take,
   input  logic             below,
   output logic             hunting,
   output logic             bnd_pulse,
   output logic [IDX_W-1:0] bnd_index,
   output logic             tmo_pulse
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TIMEOUT_SYMS - 1);

   pbd_state_e       state;
   logic [IDX_W-1:0] sym_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         sym_cnt   <= '0;
         bnd_pulse <= 1'b0;
         bnd_index <= '0;
         tmo_pulse <= 1'b0;
      end else begin
         bnd_pulse <= 1'b0;
         tmo_pulse <= 1'b0;
         if (arm) begin
            state   <= ST_HUNT;
            sym_cnt <= '0;
         end else if (take) begin
            if (below) begin
               bnd_pulse <= 1'b1;
               bnd_index <= sym_cnt;
               state     <= ST_IDLE;
            end else if (sym_cnt == LAST_IDX) begin
               tmo_pulse <= 1'b1;
               state     <= ST_IDLE;
            end else begin
               sym_cnt <= sym_cnt + 1'b1;
            end
         end
      end
   end

   assign hunting = (state == ST_HUNT);

endmodule

// File: rtl/preamble_bnd_det.sv
module preamble_bnd_det #(
   parameter int CORR_W       = 16,
   parameter int PWR_W        = 16,
   parameter int SEL_W        = 2,
   parameter int MAX_SHIFT    = 3,
   parameter int TIMEOUT_SYMS = 24,
   localparam int IDX_W  = $clog2(TIMEOUT_SYMS),
   localparam int SUM_W  = CORR_W + 1,
   localparam int PSUM_W = PWR_W + 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     arm_i,
   input  logic                     sym_valid_i,
   input  logic signed [CORR_W-1:0] corr_i,
   input  logic        [PWR_W-1:0]  pwr_i,
   input  logic        [SEL_W-1:0]  ratio_sel_i,
   output logic                     bnd_pulse_o,
   output logic        [IDX_W-1:0]  bnd_index_o,
   output logic                     tmo_pulse_o
);

   if (CORR_W < 2) begin : g_bad_corr
      $error("CORR_W must be at least 2");
   end
   if (PWR_W < 1) begin : g_bad_pwr
      $error("PWR_W must be at least 1");
   end
   if (MAX_SHIFT < 1 || MAX_SHIFT >= SUM_W) begin : g_bad_shift
      $error("MAX_SHIFT must lie in 1..CORR_W");
   end
   if (TIMEOUT_SYMS < 3) begin : g_bad_tmo
      $error("TIMEOUT_SYMS must be at least 3");
   end

   logic                     hunting;
   logic                     take;
   logic                     pair_ok;
   logic signed [SUM_W-1:0]  pair_corr;
   logic        [PSUM_W-1:0] pair_pwr;
   logic                     below;

   assign take = sym_valid_i && hunting && !arm_i;

   pbd_pair_sum #(.CORR_W(CORR_W), .PWR_W(PWR_W)) u_pair (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (arm_i),
      .take      (take),
      .corr      (corr_i),
      .pwr       (pwr_i),
      .pair_ok   (pair_ok),
      .pair_corr (pair_corr),
      .pair_pwr  (pair_pwr)
   );

   pbd_thresh #(
      .CORR_W(CORR_W), .PWR_W(PWR_W), .SEL_W(SEL_W), .MAX_SHIFT(MAX_SHIFT)
   ) u_thr (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (arm_i),
      .take      (take),
      .pair_ok   (pair_ok),
      .pair_corr (pair_corr),
      .pair_pwr  (pair_pwr),
      .sel       (ratio_sel_i),
      .below     (below)
   );

   pbd_seq #(.TIMEOUT_SYMS(TIMEOUT_SYMS)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .arm       (arm_i),
      .take      (take),
      .below     (below),
      .hunting   (hunting),
      .bnd_pulse (bnd_pulse_o),
      .bnd_index (bnd_index_o),
      .tmo_pulse (tmo_pulse_o)
   );

endmodule

// File: rtl/preamble_bnd_det_chk.sv
module preamble_bnd_det_chk #(
   parameter int TIMEOUT_SYMS = 24,
   localparam int IDX_W = $clog2(TIMEOUT_SYMS),
   localparam int CNT_W = IDX_W + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             arm_i,
   input logic             sym_valid_i,
   input logic             bnd_pulse_o,
   input logic [IDX_W-1:0] bnd_index_o,
   input logic             tmo_pulse_o
);

   // Independent count of symbols seen since the last arm.
   logic             chk_armed;
   logic [CNT_W-1:0] chk_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chk_armed <= 1'b0;
         chk_cnt   <= '0;
      end else if (arm_i) begin
         chk_armed <= 1'b1;
         chk_cnt   <= '0;
      end else if (bnd_pulse_o || tmo_pulse_o) begin
         chk_armed <= 1'b0;
      end else if (sym_valid_i && chk_armed && chk_cnt < CNT_W'(TIMEOUT_SYMS)) begin
         chk_cnt <= chk_cnt + 1'b1;
      end
   end

   a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({bnd_pulse_o, tmo_pulse_o}));

   a_r7_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      bnd_pulse_o |=> !bnd_pulse_o);

   a_r9_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_pulse_o |=> !tmo_pulse_o);

   a_r7_index_matches: assert property (@(posedge clk) disable iff (!rst_n)
      bnd_pulse_o |-> (int'(bnd_index_o) == int'(chk_cnt) - 1));

   a_r9_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_pulse_o |-> (int'(chk_cnt) == TIMEOUT_SYMS));

   a_r2_needs_symbol: assert property (@(posedge clk) disable iff (!rst_n)
      (bnd_pulse_o || tmo_pulse_o) |-> $past(sym_valid_i && !arm_i));

   a_r8_only_when_armed: assert property (@(posedge clk) disable iff (!rst_n)
      (bnd_pulse_o || tmo_pulse_o) |-> chk_armed);

   a_r3_no_early_decision: assert property (@(posedge clk) disable iff (!rst_n)
      bnd_pulse_o |-> (int'(chk_cnt) >= 3));

endmodule

bind preamble_bnd_det preamble_bnd_det_chk #(.TIMEOUT_SYMS(TIMEOUT_SYMS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .arm_i       (arm_i),
   .sym_valid_i (sym_valid_i),
   .bnd_pulse_o (bnd_pulse_o),
   .bnd_index_o (bnd_index_o),
   .tmo_pulse_o (tmo_pulse_o)
);

// File: tb/tb_preamble_bnd_det.sv
module tb_preamble_bnd_det;

   localparam int CLK_PERIOD = 10;
   localparam int IDX_W = 5;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               arm = 1'b0;
   logic               sym_valid = 1'b0;
   logic signed [15:0] corr = '0;
   logic        [15:0] pwr = '0;
   logic        [1:0]  sel = '0;
   logic               bnd_pulse;
   logic [IDX_W-1:0]   bnd_index;
   logic               tmo_pulse;

   int checks = 0;
   int errors = 0;
   int n_bnd = 0;
   int n_tmo = 0;
   int last_idx = -1;

   always #(CLK_PERIOD/2) clk = ~clk;

   preamble_bnd_det dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .arm_i       (arm),
      .sym_valid_i (sym_valid),
      .corr_i      (corr),
      .pwr_i       (pwr),
      .ratio_sel_i (sel),
      .bnd_pulse_o (bnd_pulse),
      .bnd_index_o (bnd_index),
      .tmo_pulse_o (tmo_pulse)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Record any pulse visible in the cycle after an edge.
   task automatic observe();
      if (bnd_pulse) begin
         n_bnd++;
         last_idx = int'(bnd_index);
      end
      if (tmo_pulse) n_tmo++;
   endtask

   task automatic send(input int c, input int p);
      @(negedge clk);
      sym_valid = 1'b1;
      corr = 16'(c);
      pwr = 16'(p);
      @(negedge clk);
      sym_valid = 1'b0;
      observe();
      @(negedge clk);
      observe();
   endtask

   task automatic feed(input int c, input int p, input int n);
      for (int i = 0; i < n; i++) send(c, p);
   endtask

   task automatic do_arm(input int s);
      @(negedge clk);
      sel = 2'(s);
      arm = 1'b1;
      @(negedge clk);
      arm = 1'b0;
      n_bnd = 0;
      n_tmo = 0;
      last_idx = -1;
   endtask

   task automatic t_reset();
      check(!bnd_pulse, "R1 boundary low after reset", int'(bnd_pulse), 0);
      check(!tmo_pulse, "R1 timeout low after reset", int'(tmo_pulse), 0);
   endtask

   task automatic t_idle_ignored();
      n_bnd = 0;
      n_tmo = 0;
      send(100, 100);
      send(100, 100);
      send(-100, 100);
      feed(-300, 100, 30);
      check(n_bnd == 0, "R2 no boundary while idle", n_bnd, 0);
      check(n_tmo == 0, "R2 no timeout while idle", n_tmo, 0);
   endtask

   task automatic t_nominal();
      do_arm(0);
      feed(100, 100, 21);
      check(n_bnd == 0, "R7 no boundary within repeated part", n_bnd, 0);
      feed(-100, 100, 3);
      check(n_bnd == 1, "R7 one boundary pulse", n_bnd, 1);
      check(last_idx == 21, "R7 boundary index", last_idx, 21);
      feed(50, 100, 6);
      feed(-200, 100, 10);
      check(n_bnd == 1, "R8 no further boundary after detection", n_bnd, 1);
      check(n_tmo == 0, "R8 no timeout after detection", n_tmo, 0);
   endtask

   task automatic t_early();
      do_arm(0);
      send(100, 100);
      send(-100, 100);
      check(n_bnd == 0, "R3 no decision at index 1", n_bnd, 0);
      send(-100, 100);
      check(n_bnd == 1 && last_idx == 2, "R3 first decision at index 2", last_idx, 2);
   endtask

   task automatic t_shift(input int s, input int step, input int exp_idx);
      do_arm(s);
      feed(100, 100, 5);
      send(step, 100);
      send(step, 100);
      check(n_bnd == 1 && last_idx == exp_idx, $sformatf("R6 select %0d step %0d", s, step),
            last_idx, exp_idx);
   endtask

   task automatic t_adapt();
      do_arm(0);
      feed(40, 100, 5);
      feed(15, 100, 3);
      check(n_bnd == 0, "R5 gradual decline followed by threshold", n_bnd, 0);
      send(-15, 100);
      check(n_bnd == 1 && last_idx == 8, "R5 boundary at sign flip", last_idx, 8);
   endtask

   task automatic t_power();
      do_arm(0);
      feed(100, 100, 5);
      send(60, 400);
      check(n_bnd == 1 && last_idx == 5, "R4 power sum scales threshold", last_idx, 5);
      do_arm(0);
      feed(100, 100, 5);
      send(60, 100);
      check(n_bnd == 0, "R4 same correlation at equal power passes", n_bnd, 0);
   endtask

   task automatic t_timeout();
      do_arm(1);
      feed(100, 100, 23);
      check(n_tmo == 0, "R9 no timeout before last index", n_tmo, 0);
      send(100, 100);
      check(n_tmo == 1, "R9 timeout at index 23", n_tmo, 1);
      check(n_bnd == 0, "R9 no boundary with timeout", n_bnd, 0);
      feed(-100, 100, 4);
      check(n_tmo == 1 && n_bnd == 0, "R9 search ended after timeout", n_tmo + n_bnd, 1);
   endtask

   task automatic t_rearm();
      do_arm(0);
      feed(100, 100, 10);
      do_arm(0);
      feed(100, 100, 21);
      send(-100, 100);
      check(n_bnd == 1 && last_idx == 21, "R2 rearm restarts index", last_idx, 21);
      // Arm together with a symbol: that symbol is dropped.
      @(negedge clk);
      arm = 1'b1;
      sym_valid = 1'b1;
      corr = -16'sd300;
      pwr = 16'd100;
      @(negedge clk);
      arm = 1'b0;
      sym_valid = 1'b0;
      n_bnd = 0;
      last_idx = -1;
      send(100, 100);
      send(100, 100);
      send(-100, 100);
      check(n_bnd == 1 && last_idx == 2, "R2 symbol with arm dropped", last_idx, 2);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_idle_ignored();
      t_nominal();
      t_early();
      t_shift(0, -60, 5);
      t_shift(1, -60, 5);
      t_shift(2, -60, 6);
      t_shift(3, -60, 6);
      t_shift(0, -10, 5);
      t_shift(1, -10, 6);
      t_adapt();
      t_power();
      t_timeout();
      t_rearm();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule